// File: doc/BRIEF.md
# Serial Flash Continuous-Read Sequencer

This block is the host side of an SPI link to a page-organised serial flash. The caller supplies a page number, a byte offset inside that page and a byte count, then pulses `start_i`. The block lowers chip select and sends one continuous-read command: an 8-bit opcode, a 24-bit packed address and 32 padding bits. It then keeps the serial clock running. Each byte the flash returns is presented on `data_o` with a one-cycle `valid_o` strobe.

A page holds 264 bytes, which is not a power of two, so the offset cannot simply be carried into the page number. The block checks the offset against the page size before it starts any bus activity. Once the preamble is out, no further address is sent. The flash steps through its own array, crossing page boundaries by itself, until the block has counted the requested number of bytes and raises chip select.

Top module: `sflash_stream_rd`

## Requirements
- R1: After the falling edge of `cs_n_o`, the first 64 bits on `mosi_o` are sent MSB first. They are the opcode (8 bits), then three zero bits, then `page_i` (12 bits), then `offset_i` (9 bits), then 32 zero bits.
- R2: With `op_sel_i`=0 the opcode is 0x68. With `op_sel_i`=1 it is 0xE8.
- R3: With `cpol_i`=0 the idle level of `sck_o` is low (mode 0). With `cpol_i`=1 it is high (mode 3). `mosi_o` changes only on a falling `sck_o` edge or while `cs_n_o` is high. `miso_i` is sampled on the rising edge.
- R4: Each half period of `sck_o` lasts max(`div_i`,1) system clocks. `cs_n_o` stays low for exactly (2·(64+8·count)+2)·max(`div_i`,1) cycles.
- R5: The bits on `miso_i` during the 64 preamble clocks are discarded. Each later group of 8 sampled bits is assembled MSB first and presented on `data_o` with `valid_o` high for one cycle.
- R6: A transfer produces exactly `count_i` bytes and exactly 64+8·`count_i` rising `sck_o` edges, then returns `cs_n_o` high.
- R7: `busy_o` is high from the cycle after an accepted start until `cs_n_o` rises. In that cycle `done_o` pulses for one cycle and `busy_o` is low.
- R8: A start with `offset_i` > 263 or `count_i` = 0 raises `err_o` for one cycle. `cs_n_o` stays high and `sck_o` does not toggle.
- R9: `start_i` has no effect while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse |
| page_i | input | 12 | Start page |
| offset_i | input | 9 | Start byte within page (0..263) |
| count_i | input | CNT_W | Bytes to read |
| op_sel_i | input | 1 | Opcode choice: 0 gives 0x68, 1 gives 0xE8 |
| cpol_i | input | 1 | Serial clock idle level: 0 for mode 0, 1 for mode 3 |
| div_i | input | DIV_W | Half period of the serial clock, in system clocks |
| miso_i | input | 1 | Serial data from the flash |
| cs_n_o | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the flash |
| data_o | output | 8 | Received byte |
| valid_o | output | 1 | `data_o` strobe |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer finished pulse |
| err_o | output | 1 | Request rejected pulse |

## Verification
The assertions check on every cycle that:
- the serial clock rests at its configured idle level;
- the output line holds still while the clock is high inside a frame;
- strobes appear only with chip select low;
- `done_o` and `err_o` occur only with chip select high and `busy_o` low.

The frame contents, the page-crossing data order, the exact edge and cycle counts and the effect of the divider can only be shown by the scenarios. The bench's responder decodes the command, streams a pattern derived from the wrapped address, and the bench compares the results against arithmetic expectations.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int PAGE_W   = 12;
  localparam int OFFS_W   = 9;
  localparam int PRE_BITS = 64;
  localparam int PAGE_LEN = 264;
  localparam logic [7:0] OPC_LO = 8'h68;
  localparam logic [7:0] OPC_HI = 8'hE8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LO,
    ST_HI,
    ST_HOLD
  } sfr_state_e;
endpackage

// File: rtl/sfr_tick.sv
module sfr_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i || tick_o)  cnt_q <= half_i - DIV_W'(1);
    else if (run_i)             cnt_q <= cnt_q - DIV_W'(1);
  end
endmodule

// File: rtl/sfr_rx.sv
module sfr_rx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       sample_i,
  input  logic       bit_i,
  output logic [7:0] data_o,
  output logic       valid_o
);
  logic [6:0] sr_q;
  logic [2:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (sample_i) begin
        sr_q  <= {sr_q[5:0], bit_i};
        cnt_q <= cnt_q + 3'd1;
        if (cnt_q == 3'd7) begin
          data_o  <= {sr_q, bit_i};
          valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sfr_ctrl.sv
module sfr_ctrl
  import sfr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [OFFS_W-1:0] offset_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              op_sel_i,
  input  logic              cpol_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              tick_i,
  output logic [DIV_W-1:0]  half_o,
  output logic              load_o,
  output logic              sample_o,
  output logic              cs_n_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int REM_W = CNT_W + 4;
  localparam int PRE_W = $clog2(PRE_BITS + 1);

  sfr_state_e        state_q;
  logic [PRE_BITS-1:0] tx_q;
  logic [PRE_W-1:0]  pre_q;
  logic [REM_W-1:0]  rem_q;
  logic              cpol_q;
  logic [DIV_W-1:0]  half_q;

  logic              bad, accept;
  logic [DIV_W-1:0]  half_in;
  logic [7:0]        opc;
  logic [PRE_BITS-1:0] frame;

  assign bad     = (offset_i > OFFS_W'(PAGE_LEN - 1)) || (count_i == '0);
  assign accept  = (state_q == ST_IDLE) && start_i && !bad;
  assign half_in = (div_i == '0) ? DIV_W'(1) : div_i;
  assign half_o  = (state_q == ST_IDLE) ? half_in : half_q;
  assign load_o  = accept;
  assign opc     = op_sel_i ? OPC_HI : OPC_LO;
  assign frame   = {opc, 3'b000, page_i, offset_i, 32'h0};
  assign busy_o  = (state_q != ST_IDLE);
  // rising edge is the LO->HI transition; preamble samples are dropped
  assign sample_o = (state_q == ST_LO) && tick_i && (pre_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tx_q    <= '0;
      pre_q   <= '0;
      rem_q   <= '0;
      cpol_q  <= 1'b0;
      half_q  <= DIV_W'(1);
      cs_n_o  <= 1'b1;
      sck_o   <= 1'b0;
      mosi_o  <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          sck_o  <= cpol_i;
          mosi_o <= 1'b0;
          if (start_i && bad) begin
            err_o <= 1'b1;
          end else if (accept) begin
            cpol_q  <= cpol_i;
            half_q  <= half_in;
            tx_q    <= frame << 1;
            mosi_o  <= frame[PRE_BITS-1];
            pre_q   <= PRE_W'(PRE_BITS);
            rem_q   <= REM_W'(PRE_BITS) + {count_i, 3'b000};
            cs_n_o  <= 1'b0;
            state_q <= ST_SETUP;
          end
        end
        ST_SETUP: if (tick_i) begin
          sck_o   <= 1'b0;
          state_q <= ST_LO;
        end
        ST_LO: if (tick_i) begin
          sck_o   <= 1'b1;
          rem_q   <= rem_q - REM_W'(1);
          if (pre_q != '0) pre_q <= pre_q - PRE_W'(1);
          state_q <= ST_HI;
        end
        ST_HI: if (tick_i) begin
          if (rem_q == '0) begin
            sck_o   <= cpol_q;
            state_q <= ST_HOLD;
          end else begin
            sck_o   <= 1'b0;
            mosi_o  <= tx_q[PRE_BITS-1];
            tx_q    <= tx_q << 1;
            state_q <= ST_LO;
          end
        end
        ST_HOLD: if (tick_i) begin
          cs_n_o  <= 1'b1;
          sck_o   <= cpol_q;
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sflash_stream_rd.sv
module sflash_stream_rd #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [11:0]      page_i,
  input  logic [8:0]       offset_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             op_sel_i,
  input  logic             cpol_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             miso_i,
  output logic             cs_n_o,
  output logic             sck_o,
  output logic             mosi_o,
  output logic [7:0]       data_o,
  output logic             valid_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  logic             tick, load, sample;
  logic [DIV_W-1:0] half;

  sfr_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .load_i (load),
    .half_i (half),
    .tick_o (tick)
  );

  sfr_ctrl #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .page_i   (page_i),
    .offset_i (offset_i),
    .count_i  (count_i),
    .op_sel_i (op_sel_i),
    .cpol_i   (cpol_i),
    .div_i    (div_i),
    .tick_i   (tick),
    .half_o   (half),
    .load_o   (load),
    .sample_o (sample),
    .cs_n_o   (cs_n_o),
    .sck_o    (sck_o),
    .mosi_o   (mosi_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .err_o    (err_o)
  );

  sfr_rx u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (load),
    .sample_i (sample),
    .bit_i    (miso_i),
    .data_o   (data_o),
    .valid_o  (valid_o)
  );
endmodule

// File: rtl/sfr_chk.sv
module sfr_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cpol_i,
  input logic cs_n_o,
  input logic sck_o,
  input logic mosi_o,
  input logic valid_o,
  input logic busy_o,
  input logic done_o,
  input logic err_o
);
  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !busy_o && !$past(busy_o) && !$past(done_o)) |-> (sck_o == $past(cpol_i))); // R3

  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && !$past(cs_n_o) && sck_o && $past(sck_o)) |-> $stable(mosi_o)); // R3

  AST_VALID_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !cs_n_o); // R5

  AST_CS_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_o |-> busy_o); // R7

  AST_DONE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_n_o && !busy_o)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7

  AST_ERR_NO_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (cs_n_o && !busy_o)); // R8
endmodule

bind sflash_stream_rd sfr_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cpol_i  (cpol_i),
  .cs_n_o  (cs_n_o),
  .sck_o   (sck_o),
  .mosi_o  (mosi_o),
  .valid_o (valid_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .err_o   (err_o)
);

// File: tb/sflash_stream_rd_tb.sv
module sflash_stream_rd_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] page = '0;
  logic [8:0]  offs = '0;
  logic [15:0] cnt = '0;
  logic        op_sel = 1'b0;
  logic        cpol = 1'b0;
  logic [7:0]  div = 8'd1;
  logic        miso = 1'b0;
  logic        cs_n, sck, mosi, valid, busy, done, err;
  logic [7:0]  data;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  sflash_stream_rd u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .page_i(page), .offset_i(offs),
    .count_i(cnt), .op_sel_i(op_sel), .cpol_i(cpol), .div_i(div), .miso_i(miso),
    .cs_n_o(cs_n), .sck_o(sck), .mosi_o(mosi), .data_o(data), .valid_o(valid),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  function automatic logic [7:0] pat(int pg, int of);
    return 8'((pg * 37 + of * 5 + (of / 256) * 91) & 255);
  endfunction

  function automatic logic [7:0] exp_byte(int pg, int of, int k);
    int lin;
    lin = (pg * 264 + of + k) % (4096 * 264);
    return pat(lin / 264, lin % 264);
  endfunction

  // behavioural flash responder
  logic [63:0] cmd;
  int          redges;
  always @(negedge cs_n) begin
    redges = 0;
    cmd    = '0;
    miso   = 1'b1;
  end
  always @(posedge sck) if (!cs_n) begin
    if (redges < 64) cmd = {cmd[62:0], mosi};
    redges++;
  end
  always @(negedge sck) if (!cs_n) begin
    if (redges >= 64) begin
      automatic int rel = redges - 64;
      automatic logic [7:0] b = exp_byte(int'(cmd[52:41]), int'(cmd[40:32]), rel / 8);
      miso = b[7 - (rel % 8)];
    end else begin
      miso = redges[0];
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_xfer(int pg, int of, int n, bit os, bit cp, int dv, bit poke);
    logic [7:0] got [0:15];
    int nb = 0, cs_low = 0, cyc = 0, hv;
    bit seen_done = 0;
    logic [63:0] exp_cmd;
    hv = (dv == 0) ? 1 : dv;
    @(negedge clk);
    page = 12'(pg); offs = 9'(of); cnt = 16'(n); op_sel = os; cpol = cp; div = 8'(dv);
    repeat (3) @(negedge clk);
    check(sck == cp, "R3", "idle sck level", sck, cp);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1 && cs_n == 1'b0, "R7", "busy after start", {busy, cs_n}, 2'b10);
    cs_low = 1;
    while (!seen_done && cyc < 20000) begin
      if (poke && cyc == 20) begin start = 1'b1; page = 12'(pg + 1); offs = 9'd0; end
      else start = 1'b0;
      @(negedge clk);
      cyc++;
      if (valid) begin
        if (nb < 16) got[nb] = data;
        nb++;
      end
      if (done) begin
        seen_done = 1;
        check(cs_n == 1'b1 && busy == 1'b0, "R7", "done with cs high", {cs_n, busy}, 2'b10);
      end else if (!cs_n) cs_low++;
    end
    start = 1'b0;
    check(seen_done, "R7", "done seen", seen_done, 1);
    exp_cmd = {(os ? 8'hE8 : 8'h68), 3'b000, 12'(pg), 9'(of), 32'h0};
    check(cmd == exp_cmd, os ? "R2" : "R1", "command frame", cmd, exp_cmd);
    check(redges == 64 + 8 * n, "R6", "rising edges", redges, 64 + 8 * n);
    check(nb == n, "R6", "byte count", nb, n);
    check(cs_low == (2 * (64 + 8 * n) + 2) * hv, "R4", "cs low cycles", cs_low,
          (2 * (64 + 8 * n) + 2) * hv);
    for (int k = 0; k < n && k < 16; k++)
      check(got[k] == exp_byte(pg, of, k), "R5", "data byte", got[k], exp_byte(pg, of, k));
    if (poke) begin
      int low = 0;
      repeat (40) begin
        @(negedge clk);
        if (!cs_n || busy) low++;
      end
      check(low == 0, "R9", "no second frame", low, 0);
    end
    repeat (2) @(negedge clk);
    check(sck == cp, "R3", "sck back at idle", sck, cp);
  endtask

  task automatic run_reject(int of, int n);
    int toggles = 0;
    logic last;
    @(negedge clk);
    offs = 9'(of); cnt = 16'(n); page = 12'd3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(err == 1'b1 && cs_n == 1'b1 && busy == 1'b0, "R8", "reject pulse",
          {err, cs_n, busy}, 3'b110);
    last = sck;
    repeat (20) begin
      @(negedge clk);
      if (sck != last || !cs_n || err) toggles++;
      last = sck;
    end
    check(toggles == 0, "R8", "bus quiet after reject", toggles, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1 && busy == 1'b0 && valid == 1'b0, "R7", "reset state",
          {cs_n, busy, valid}, 3'b100);
    rst_n = 1'b1;
    for (int cp = 0; cp < 2; cp++)
      for (int os = 0; os < 2; os++)
        for (int dv = 0; dv < 4; dv++) begin
          run_xfer(5, 0, 3, os[0], cp[0], dv, 0);
          run_xfer(7, 262, 4, os[0], cp[0], dv, 0);   // crosses into next page
          run_xfer(4095, 261, 4, os[0], cp[0], dv, 0); // wraps to page 0
          run_xfer(123, 100, 1, os[0], cp[0], dv, 0);
        end
    run_xfer(10, 50, 6, 1'b0, 1'b0, 2, 1);
    run_xfer(11, 263, 5, 1'b1, 1'b1, 1, 1);
    run_reject(264, 4);
    run_reject(511, 1);
    run_reject(10, 0);
    run_xfer(0, 263, 2, 1'b0, 1'b1, 3, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule